// File: doc/BRIEF.md
# USB Device Power Control Register

This block holds the device-level power and link controls of a USB function controller. Software reaches it through a small byte-wide register port. The line-state detector feeds it single-cycle pulses when it sees bus reset, suspend or resume signalling. In return the block enables or inhibits the function and reports whether the link is suspended. It drives remote-wakeup resume signalling, issues a one-cycle reset pulse to the rest of the USB logic (address, endpoint index, endpoint status, FIFO flush) and raises interrupt flags.

The function starts inhibited after a power-on reset. Once software enables it, only a power-on reset or a software-forced module reset can inhibit it again. Line events are honoured only while the function is enabled. Suspend entry also needs suspend detection to be turned on. Suspend ends on a detected resume, on a software-generated resume, on a bus reset, or on any module reset.

There are three registers, chosen by `reg_sel`:

- **Power register (select 0):**
  - bit 7: isochronous update enable.
  - bit 4: inhibit.
  - bit 3: reset. A write of 1 forces a module reset. The bit reads 1 after a bus reset.
  - bit 2: resume drive.
  - bit 1: suspended status, read-only.
  - bit 0: suspend-detect enable.
  - Other bits read 0.
- **Flag register (select 1):**
  - bit 0: suspend.
  - bit 1: resume.
  - bit 2: reset.
  - Flags clear when read.
- **Enable register (select 2):** uses the same bit layout as the flag register.

Top module: `usb_pwrctl`

## Requirements
- R1: After power-on reset the power register reads 0x10, the enable register reads 0x06, the flag register reads 0x00, and func_enable, suspended, resume_drive, usb_rst_pulse and irq are all 0.
- R2: Writing the power register with bit 4 = 0 sets func_enable in the next cycle. A later write with bit 4 = 1 leaves func_enable at 1 and bit 4 reading 0.
- R3: While the function is inhibited, line reset, suspend and resume pulses have no effect. There is no usb_rst_pulse, no suspend, no flag, and bit 3 stays 0.
- R4: Writing the power register with bit 3 = 1 gives usb_rst_pulse high for exactly one cycle, starting in the next cycle. All three registers return to their R1 values, and bit 3 reads 0.
- R5: A line reset pulse while the function is enabled gives a one-cycle usb_rst_pulse in the next cycle and leaves func_enable unchanged. Power bit 3 then reads 1 until the next write to the power register.
- R6: A bus reset leaves suspend and clears every flag except the reset flag (flag register reads 0x04). It sets enable bits 2 and 1 to 1 and leaves enable bit 0 unchanged.
- R7: A suspend pulse puts the block in suspend only when power bit 0 is 1. When it does, suspended and power bit 1 read 1 in the next cycle, and flag bit 0 is set only if enable bit 0 is 1.
- R8: A resume pulse while suspended clears suspended in the next cycle and sets flag bit 1 if enable bit 1 is 1. A resume pulse while not suspended has no effect.
- R9: Writing power bit 2 = 1 while suspended sets resume_drive and clears suspended in the next cycle. resume_drive holds until a write with bit 2 = 0. A write with bit 2 = 1 while not suspended is ignored.
- R10: A flag register read returns the flags and clears them after that cycle, but a flag set in the same cycle survives. irq is 1 exactly when some flag and its enable are both 1.
- R11: Writes to the flag register are ignored. iso_update follows power bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_sel | input | ADDR_W | Register select: 0 power, 1 flags, 2 enables |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears flags when selecting the flag register) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| line_reset_pulse | input | 1 | Bus reset seen by the line-state detector |
| line_suspend_pulse | input | 1 | Suspend signalling seen |
| line_resume_pulse | input | 1 | Resume signalling seen |
| usb_rst_pulse | output | 1 | One-cycle reset for the rest of the USB logic |
| suspended | output | 1 | Link is suspended |
| resume_drive | output | 1 | Drive remote-wakeup resume signalling |
| func_enable | output | 1 | Function enabled (inhibit cleared) |
| iso_update | output | 1 | Isochronous update enable |
| irq | output | 1 | Interrupt request |

## Verification
Each piece of internal state can be read back through the power, flag or enable register. A wrong link state or sticky bit therefore shows up on suspended, resume_drive, func_enable or the register port in the cycle after the event that caused it. A missed or duplicated module reset appears as a wrong width of usb_rst_pulse, or as enable and power values that differ from their defaults right after the pulse. The clear-on-read behaviour of the flags is checked by reading twice, and by reading while a flag is being set in the same cycle.

// File: rtl/usb_pwrctl_pkg.sv
`timescale 1ns/1ps
package usb_pwrctl_pkg;
  localparam int REG_W = 8;

  // power register field positions
  localparam int PWR_ISO_B = 7;
  localparam int PWR_INH_B = 4;
  localparam int PWR_RST_B = 3;
  localparam int PWR_RSM_B = 2;
  localparam int PWR_SUS_B = 1;
  localparam int PWR_SDE_B = 0;

  // flag / enable register bit positions
  localparam int IRQ_SUS_B = 0;
  localparam int IRQ_RSM_B = 1;
  localparam int IRQ_RST_B = 2;
  localparam int IRQ_N     = 3;

  // register selects
  localparam int SEL_PWR  = 0;
  localparam int SEL_FLAG = 1;
  localparam int SEL_IEN  = 2;

  // enables forced on by any reset: all but suspend
  localparam logic [IRQ_N-1:0] IEN_DEFAULT = 3'b110;

  typedef enum logic [1:0] {
    LS_ACTIVE = 2'd0,
    LS_SUSP   = 2'd1,
    LS_DRIVE  = 2'd2
  } link_st_e;
endpackage

// File: rtl/usb_pwrctl_rstsync.sv
`timescale 1ns/1ps
module usb_pwrctl_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/usb_pwrctl_cfg.sv
`timescale 1ns/1ps
module usb_pwrctl_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic pwr_wr,
  input  logic iso_w,
  input  logic inh_w,
  input  logic sde_w,
  input  logic bus_rst,
  output logic inhibit,
  output logic iso_en,
  output logic sde,
  output logic rst_seen
);
  logic inh_q, iso_q, sde_q, rsb_q;
  logic inh_d, iso_d, sde_d, rsb_d;
  logic upd;

  always_comb begin
    inh_d = inh_q;
    iso_d = iso_q;
    sde_d = sde_q;
    rsb_d = rsb_q;
    upd   = sw_rst | pwr_wr | bus_rst;
    if (sw_rst) begin
      inh_d = 1'b1;
      iso_d = 1'b0;
      sde_d = 1'b0;
      rsb_d = 1'b0;
    end else begin
      if (pwr_wr) begin
        iso_d = iso_w;
        // inhibit can only be cleared by software, never set
        inh_d = inh_q & inh_w;
        sde_d = sde_w;
        rsb_d = 1'b0;
      end
      if (bus_rst) rsb_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q <= 1'b1;
      iso_q <= 1'b0;
      sde_q <= 1'b0;
      rsb_q <= 1'b0;
    end else if (upd) begin
      inh_q <= inh_d;
      iso_q <= iso_d;
      sde_q <= sde_d;
      rsb_q <= rsb_d;
    end
  end

  assign inhibit  = inh_q;
  assign iso_en   = iso_q;
  assign sde      = sde_q;
  assign rst_seen = rsb_q;
endmodule

// File: rtl/usb_pwrctl_link.sv
`timescale 1ns/1ps
module usb_pwrctl_link
  import usb_pwrctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic bus_rst,
  input  logic enabled,
  input  logic sde,
  input  logic sus_seen,
  input  logic rsm_seen,
  input  logic pwr_wr,
  input  logic rsm_bit,
  output logic suspended,
  output logic resume_drive,
  output logic sus_evt,
  output logic rsm_evt
);
  link_st_e st_q, st_d;
  logic     st_en;

  always_comb begin
    st_d    = st_q;
    sus_evt = 1'b0;
    rsm_evt = 1'b0;
    if (sw_rst) begin
      st_d = LS_ACTIVE;
    end else begin
      unique case (st_q)
        LS_ACTIVE: begin
          if (!bus_rst && enabled && sde && sus_seen) begin
            st_d    = LS_SUSP;
            sus_evt = 1'b1;
          end
        end
        LS_SUSP: begin
          if (bus_rst) begin
            st_d = LS_ACTIVE;
          end else if (enabled && rsm_seen) begin
            st_d    = LS_ACTIVE;
            rsm_evt = 1'b1;
          end else if (pwr_wr && rsm_bit) begin
            st_d = LS_DRIVE;
          end
        end
        LS_DRIVE: begin
          if (pwr_wr && !rsm_bit) st_d = LS_ACTIVE;
        end
        default: st_d = LS_ACTIVE;
      endcase
    end
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= LS_ACTIVE;
    else if (st_en) st_q <= st_d;
  end

  assign suspended    = (st_q == LS_SUSP);
  assign resume_drive = (st_q == LS_DRIVE);
endmodule

// File: rtl/usb_pwrctl_irq.sv
`timescale 1ns/1ps
module usb_pwrctl_irq
  import usb_pwrctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             bus_rst,
  input  logic             sus_evt,
  input  logic             rsm_evt,
  input  logic             rd_clr,
  input  logic             ien_wr,
  input  logic [IRQ_N-1:0] ien_w,
  output logic [IRQ_N-1:0] flags,
  output logic [IRQ_N-1:0] ien,
  output logic             irq
);
  logic [IRQ_N-1:0] flg_q, flg_d, ien_q, ien_d, set_v;
  logic             upd;

  always_comb begin
    set_v            = '0;
    set_v[IRQ_SUS_B] = sus_evt & ien_q[IRQ_SUS_B];
    set_v[IRQ_RSM_B] = rsm_evt & ien_q[IRQ_RSM_B];
    flg_d = flg_q;
    ien_d = ien_q;
    if (sw_rst) begin
      flg_d = '0;
      ien_d = IEN_DEFAULT;
    end else if (bus_rst) begin
      // reset enable is forced on here, so the reset flag always follows
      flg_d            = '0;
      flg_d[IRQ_RST_B] = 1'b1;
      ien_d            = ien_q | IEN_DEFAULT;
    end else begin
      if (rd_clr) flg_d = '0;
      flg_d = flg_d | set_v;
      if (ien_wr) ien_d = ien_w;
    end
    upd = (flg_d != flg_q) | (ien_d != ien_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      ien_q <= IEN_DEFAULT;
    end else if (upd) begin
      flg_q <= flg_d;
      ien_q <= ien_d;
    end
  end

  assign flags = flg_q;
  assign ien   = ien_q;
  assign irq   = |(flg_q & ien_q);
endmodule

// File: rtl/usb_pwrctl.sv
`timescale 1ns/1ps
module usb_pwrctl
  import usb_pwrctl_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              line_reset_pulse,
  input  logic              line_suspend_pulse,
  input  logic              line_resume_pulse,
  output logic              usb_rst_pulse,
  output logic              suspended,
  output logic              resume_drive,
  output logic              func_enable,
  output logic              iso_update,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(SEL_PWR);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(SEL_FLAG);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(SEL_IEN);

  logic rst_int_n;
  logic pwr_wr, ien_wr, rd_clr, sw_rst, bus_rst;
  logic inhibit, sde, rst_seen, sus_evt, rsm_evt;
  logic rst_pulse_q;
  logic [IRQ_N-1:0] flags, ien;
  logic unused_wbits;

  usb_pwrctl_rstsync #(.STAGES(SYNC_STAGE)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // register decode
  assign pwr_wr  = reg_wr && (reg_sel == A_PWR);
  assign ien_wr  = reg_wr && (reg_sel == A_IEN);
  assign rd_clr  = reg_rd && (reg_sel == A_FLAG);
  assign sw_rst  = pwr_wr && reg_wdata[PWR_RST_B];
  assign bus_rst = line_reset_pulse && !inhibit && !sw_rst;
  assign unused_wbits = ^{reg_wdata[REG_W-2:PWR_INH_B+1], reg_wdata[PWR_SUS_B],
                          reg_wdata[REG_W-1:IRQ_N] & 5'b0};

  usb_pwrctl_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sw_rst   (sw_rst),
    .pwr_wr   (pwr_wr),
    .iso_w    (reg_wdata[PWR_ISO_B]),
    .inh_w    (reg_wdata[PWR_INH_B]),
    .sde_w    (reg_wdata[PWR_SDE_B]),
    .bus_rst  (bus_rst),
    .inhibit  (inhibit),
    .iso_en   (iso_update),
    .sde      (sde),
    .rst_seen (rst_seen)
  );

  usb_pwrctl_link u_link (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sw_rst       (sw_rst),
    .bus_rst      (bus_rst),
    .enabled      (!inhibit),
    .sde          (sde),
    .sus_seen     (line_suspend_pulse),
    .rsm_seen     (line_resume_pulse),
    .pwr_wr       (pwr_wr),
    .rsm_bit      (reg_wdata[PWR_RSM_B]),
    .suspended    (suspended),
    .resume_drive (resume_drive),
    .sus_evt      (sus_evt),
    .rsm_evt      (rsm_evt)
  );

  usb_pwrctl_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sw_rst  (sw_rst),
    .bus_rst (bus_rst),
    .sus_evt (sus_evt),
    .rsm_evt (rsm_evt),
    .rd_clr  (rd_clr),
    .ien_wr  (ien_wr),
    .ien_w   (reg_wdata[IRQ_N-1:0]),
    .flags   (flags),
    .ien     (ien),
    .irq     (irq)
  );

  // one-cycle module reset towards the rest of the USB logic
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rst_pulse_q <= 1'b0;
    else            rst_pulse_q <= sw_rst | bus_rst;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == A_PWR) begin
      reg_rdata[PWR_ISO_B] = iso_update;
      reg_rdata[PWR_INH_B] = inhibit;
      reg_rdata[PWR_RST_B] = rst_seen;
      reg_rdata[PWR_RSM_B] = resume_drive;
      reg_rdata[PWR_SUS_B] = suspended;
      reg_rdata[PWR_SDE_B] = sde;
    end else if (reg_sel == A_FLAG) begin
      reg_rdata[IRQ_N-1:0] = flags;
    end else if (reg_sel == A_IEN) begin
      reg_rdata[IRQ_N-1:0] = ien;
    end
  end

  assign usb_rst_pulse = rst_pulse_q;
  assign func_enable   = !inhibit;
endmodule

// File: rtl/usb_pwrctl_chk.sv
`timescale 1ns/1ps
module usb_pwrctl_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [ADDR_W-1:0] reg_sel,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic              line_reset_pulse,
  input logic              line_suspend_pulse,
  input logic              line_resume_pulse,
  input logic              usb_rst_pulse,
  input logic              suspended,
  input logic              resume_drive,
  input logic              func_enable
);
  logic force_rst;
  assign force_rst = reg_wr && (reg_sel == '0) && reg_wdata[3];

  // R2
  inhibit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    func_enable && !force_rst |=> func_enable);

  // R3
  inhibited_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !func_enable && !force_rst |=> !usb_rst_pulse);

  // R4
  sw_reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    force_rst |=> usb_rst_pulse && !func_enable && !suspended);

  // R5
  bus_reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    func_enable && line_reset_pulse |=> usb_rst_pulse);

  // R7
  suspend_entry_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(suspended) |-> $past(line_suspend_pulse) && $past(func_enable));

  // R8
  resume_exit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    suspended && line_resume_pulse |=> !suspended);

  // R9
  wake_from_susp_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(resume_drive) |-> $past(suspended));
endmodule

bind usb_pwrctl usb_pwrctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk                (clk),
  .rst_int_n          (rst_int_n),
  .reg_sel            (reg_sel),
  .reg_wr             (reg_wr),
  .reg_wdata          (reg_wdata),
  .line_reset_pulse   (line_reset_pulse),
  .line_suspend_pulse (line_suspend_pulse),
  .line_resume_pulse  (line_resume_pulse),
  .usb_rst_pulse      (usb_rst_pulse),
  .suspended          (suspended),
  .resume_drive       (resume_drive),
  .func_enable        (func_enable)
);

// File: tb/usb_pwrctl_test.sv
`timescale 1ns/1ps
module usb_pwrctl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_sel;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       line_reset_pulse, line_suspend_pulse, line_resume_pulse;
  logic       usb_rst_pulse, suspended, resume_drive, func_enable, iso_update, irq;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  usb_pwrctl #(.ADDR_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_reset_pulse(line_reset_pulse), .line_suspend_pulse(line_suspend_pulse),
    .line_resume_pulse(line_resume_pulse), .usb_rst_pulse(usb_rst_pulse),
    .suspended(suspended), .resume_drive(resume_drive), .func_enable(func_enable),
    .iso_update(iso_update), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [1:0] sel, input logic [7:0] exp);
    logic [7:0] v;
    @(negedge clk);
    reg_sel = sel; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(req, v, exp);
  endtask

  // kind: 0 reset, 1 suspend, 2 resume
  task automatic pulse(input int kind);
    @(negedge clk);
    line_reset_pulse   = (kind == 0);
    line_suspend_pulse = (kind == 1);
    line_resume_pulse  = (kind == 2);
    @(negedge clk);
    line_reset_pulse = 1'b0; line_suspend_pulse = 1'b0; line_resume_pulse = 1'b0;
  endtask

  task automatic t_reset_defaults;
    chk("R1 func_enable", 8'(func_enable), 8'h0);
    chk("R1 outputs", {4'h0, suspended, resume_drive, usb_rst_pulse, irq}, 8'h0);
    rdchk("R1 power", 2'd0, 8'h10);
    rdchk("R1 enables", 2'd2, 8'h06);
    rdchk("R1 flags", 2'd1, 8'h00);
  endtask

  task automatic t_inhibited;
    wr(2'd0, 8'h11);
    pulse(1);
    chk("R3 no suspend", 8'(suspended), 8'h0);
    pulse(0);
    chk("R3 no reset pulse", 8'(usb_rst_pulse), 8'h0);
    pulse(2);
    rdchk("R3 power", 2'd0, 8'h11);
    rdchk("R3 flags", 2'd1, 8'h00);
  endtask

  task automatic t_enable;
    wr(2'd0, 8'h01);
    chk("R2 enabled", 8'(func_enable), 8'h1);
    rdchk("R2 power", 2'd0, 8'h01);
    wr(2'd0, 8'h11);
    chk("R2 sticky", 8'(func_enable), 8'h1);
    rdchk("R2 inhibit stays 0", 2'd0, 8'h01);
    wr(2'd0, 8'h81);
    chk("R11 iso on", 8'(iso_update), 8'h1);
    rdchk("R11 power iso", 2'd0, 8'h81);
    wr(2'd0, 8'h01);
    chk("R11 iso off", 8'(iso_update), 8'h0);
    wr(2'd1, 8'h07);
    rdchk("R11 flag write ignored", 2'd1, 8'h00);
    chk("R11 irq", 8'(irq), 8'h0);
  endtask

  task automatic t_suspend_resume;
    wr(2'd0, 8'h00);
    pulse(1);
    chk("R7 needs detect enable", 8'(suspended), 8'h0);
    wr(2'd0, 8'h01);
    pulse(1);
    chk("R7 suspended", 8'(suspended), 8'h1);
    rdchk("R7 power status", 2'd0, 8'h03);
    rdchk("R7 no flag when disabled", 2'd1, 8'h00);
    pulse(2);
    chk("R8 resumed", 8'(suspended), 8'h0);
    chk("R10 irq set", 8'(irq), 8'h1);
    rdchk("R8 resume flag", 2'd1, 8'h02);
    rdchk("R10 cleared on read", 2'd1, 8'h00);
    chk("R10 irq cleared", 8'(irq), 8'h0);
    wr(2'd2, 8'h07);
    pulse(1);
    rdchk("R7 suspend flag", 2'd1, 8'h01);
    pulse(2);
    rdchk("R8 resume flag again", 2'd1, 8'h02);
    pulse(2);
    chk("R8 idle resume", 8'(suspended), 8'h0);
    rdchk("R8 idle resume no flag", 2'd1, 8'h00);
  endtask

  task automatic t_remote_wake;
    wr(2'd0, 8'h05);
    chk("R9 ignored when active", 8'(resume_drive), 8'h0);
    rdchk("R9 power unchanged", 2'd0, 8'h01);
    pulse(1);
    rdchk("R9 clear susp flag", 2'd1, 8'h01);
    wr(2'd0, 8'h05);
    chk("R9 drive on", {suspended, resume_drive}, 8'h01);
    rdchk("R9 power drive", 2'd0, 8'h05);
    repeat (3) @(negedge clk);
    chk("R9 drive held", 8'(resume_drive), 8'h1);
    wr(2'd0, 8'h01);
    chk("R9 drive off", 8'(resume_drive), 8'h0);
  endtask

  task automatic t_bus_reset;
    wr(2'd2, 8'h01);
    pulse(1);
    chk("R6 suspended before", 8'(suspended), 8'h1);
    pulse(0);
    chk("R5 pulse", 8'(usb_rst_pulse), 8'h1);
    chk("R6 suspend left", 8'(suspended), 8'h0);
    @(negedge clk);
    chk("R5 pulse one cycle", 8'(usb_rst_pulse), 8'h0);
    chk("R5 still enabled", 8'(func_enable), 8'h1);
    rdchk("R5 reset bit", 2'd0, 8'h09);
    rdchk("R6 enables", 2'd2, 8'h07);
    rdchk("R6 flags", 2'd1, 8'h04);
    wr(2'd0, 8'h01);
    rdchk("R5 reset bit cleared", 2'd0, 8'h01);
  endtask

  task automatic t_read_race;
    logic [7:0] v;
    @(negedge clk);
    reg_sel = 2'd1; reg_rd = 1'b1; line_suspend_pulse = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; line_suspend_pulse = 1'b0;
    chk("R10 read before set", v, 8'h00);
    rdchk("R10 concurrent set kept", 2'd1, 8'h01);
    pulse(2);
    rdchk("R10 resume flag", 2'd1, 8'h02);
  endtask

  task automatic t_sw_reset;
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h81);
    pulse(1);
    wr(2'd0, 8'h08);
    chk("R4 pulse", 8'(usb_rst_pulse), 8'h1);
    chk("R4 disabled", {func_enable, suspended, iso_update}, 8'h0);
    @(negedge clk);
    chk("R4 pulse one cycle", 8'(usb_rst_pulse), 8'h0);
    rdchk("R4 power default", 2'd0, 8'h10);
    rdchk("R4 enables default", 2'd2, 8'h06);
    rdchk("R4 flags cleared", 2'd1, 8'h00);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_sel = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    line_reset_pulse = 1'b0; line_suspend_pulse = 1'b0; line_resume_pulse = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_defaults();
    t_inhibited();
    t_enable();
    t_suspend_resume();
    t_remote_wake();
    t_bus_reset();
    t_read_race();
    t_sw_reset();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule